// File: doc/BRIEF.md
# Fractional Pulse-Swallowing Clock Adapter

This block lets switched-capacitor filter timing run at an effective 1.536 MHz when the master clock is either 1.536 MHz or 1.544 MHz. It runs on the master clock. It produces a clock-enable that downstream logic qualifies its registers with. In swallow mode the enable is removed for one master cycle out of every 193. In pass mode the enable stays high. Either way, 1536 enabled cycles occur per millisecond.

A second output is a one-cycle sample tick. It fires on every twelfth enabled cycle, which gives 128 kHz. A swallowed cycle does not count toward the next tick, so the tick rate is exact in both modes.

The rate select is sampled only at the boundary between 193-cycle frames, so a frame is never partly swallowed. While reset is held, the select is captured to set the mode of the first frame. All state is static, so the master clock may stop and restart at any time without any loss of position.

Top module: `swallow_clock_adapter`

## Requirements
- R1: While the reset is held and in the first cycle after it is released, the enable is high and the tick is low.
- R2: With the select at 0 (swallow mode), the enable is low for exactly one cycle in every 193 cycles. The first low cycle is cycle 193 after reset release, where the first cycle after release is cycle 1.
- R3: With the select at 1 (pass mode), the enable stays high on every cycle.
- R4: A change of the select takes effect only at the end of the current 193-cycle frame. The select value present in the last cycle of a frame sets the mode of the whole next frame.
- R5: The tick is a one-cycle pulse on every 12th enabled cycle counted from reset. The first tick falls in cycle 12 of a pass-mode run.
- R6: A swallowed cycle does not advance the tick count. In swallow mode the tick after cycle 192 falls in cycle 205, and a 193-cycle frame holds exactly 16 ticks.
- R7: If the master clock stops and later restarts, the count sequence continues from where it stopped.
- R8: The select level held during reset sets the mode of the first frame, even if the select changes right after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous reset, active low |
| rateSel | input | 1 | 1: master is 1.536 MHz (pass); 0: master is 1.544 MHz (swallow) |
| clkEn | output | 1 | Clock-enable for filter logic, low on swallowed cycles |
| sampleTick | output | 1 | One-cycle pulse every 12 enabled cycles |

## Verification
A frame counter that is off by even one cycle moves the dropped enable away from cycle 193k. A run of one frame exposes this. A mode flag that updates outside the frame boundary shows within one frame, either as a missing drop or as a drop that should not occur. A tick counter that advances on a swallowed cycle moves every later tick one cycle early. This is visible at the first tick after the first drop, within 205 cycles.

// File: rtl/swallow_clock_pkg.sv
`timescale 1ns/1ps
package swallow_clock_pkg;
  // Strobes from the frame control to the tick datapath
  typedef struct packed {
    logic enable;      // this master cycle counts as an internal clock
    logic swallowNow;  // this master cycle is the deleted one
  } swallowStrobeT;
endpackage

// File: rtl/swallow_frame_ctrl.sv
`timescale 1ns/1ps
module swallow_frame_ctrl
  import swallow_clock_pkg::*;
#(
  parameter int PERIOD = 193
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rateSel,
  output swallowStrobeT strb
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phaseCnt;
  logic          swallowMode;
  logic          atLast;

  assign atLast = (phaseCnt == LAST);

  // Frame counter; the mode is captured during reset and at each frame end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt    <= '0;
      swallowMode <= ~rateSel;
    end else begin
      phaseCnt <= atLast ? '0 : phaseCnt + 1'b1;
      if (atLast) swallowMode <= ~rateSel;
    end
  end

  always_comb begin
    strb.swallowNow = atLast && swallowMode;
    strb.enable     = !(atLast && swallowMode);
  end

  // Spacing monitor: cycles since the last dropped enable, saturating
  logic [CW:0] sinceDrop;
  logic        dropSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceDrop <= '0;
      dropSeen  <= 1'b0;
    end else if (!strb.enable) begin
      sinceDrop <= '0;
      dropSeen  <= 1'b1;
    end else if (sinceDrop != '1) begin
      sinceDrop <= sinceDrop + 1'b1;
    end
  end

  // R2
  drop_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enable && dropSeen) |-> (sinceDrop >= (CW+1)'(PERIOD - 1)));
  // R2
  single_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enable |=> strb.enable);
  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !atLast |=> $stable(swallowMode));
  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    atLast |=> (phaseCnt == '0));
endmodule

// File: rtl/swallow_tick_path.sv
`timescale 1ns/1ps
module swallow_tick_path
  import swallow_clock_pkg::*;
#(
  parameter int TICK_DIV = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  swallowStrobeT strb,
  output logic          sampleTick
);
  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int TW = $clog2(TICK_DIV);
      localparam logic [TW-1:0] TLAST = TW'(TICK_DIV - 1);
      logic [TW-1:0] tickCnt;

      always_ff @(posedge clk) begin
        if (!rstN)            tickCnt <= '0;
        else if (strb.enable) tickCnt <= (tickCnt == TLAST) ? '0 : tickCnt + 1'b1;
      end

      assign sampleTick = strb.enable && (tickCnt == TLAST);

      // R6
      hold_on_swallow_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.swallowNow |=> $stable(tickCnt));
      // R5
      tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
        sampleTick |=> !sampleTick);
    end else begin : g_pass
      assign sampleTick = strb.enable;
    end
  endgenerate

  // R6
  no_tick_on_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.swallowNow |-> !sampleTick);
endmodule

// File: rtl/swallow_clock_adapter.sv
`timescale 1ns/1ps
module swallow_clock_adapter
  import swallow_clock_pkg::*;
#(
  parameter int PERIOD   = 193,
  parameter int TICK_DIV = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic rateSel,
  output logic clkEn,
  output logic sampleTick
);
  swallowStrobeT strb;

  swallow_frame_ctrl #(.PERIOD(PERIOD)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rateSel (rateSel),
    .strb    (strb)
  );

  swallow_tick_path #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sampleTick (sampleTick)
  );

  assign clkEn = strb.enable;

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rstN |=> (clkEn && !sampleTick));
endmodule

// File: tb/sim_swallow_clock_adapter.sv
`timescale 1ns/1ps
module sim_swallow_clock_adapter;
  logic clk = 1'b0;
  logic clkRun = 1'b1;
  logic rstN = 1'b0;
  logic rateSel = 1'b1;
  logic clkEn, sampleTick;

  always #5 if (clkRun) clk = ~clk;

  swallow_clock_adapter u0 (
    .clk(clk), .rstN(rstN), .rateSel(rateSel),
    .clkEn(clkEn), .sampleTick(sampleTick)
  );

  int nTests = 0, nFail = 0;
  int curCyc, lowCount, tickCount, firstLow;
  bit lowSeen  [0:2047];
  bit tickSeen [0:2047];

  // rows: select, cycles, expected drops, expected ticks, first drop cycle
  localparam int NVEC = 6;
  localparam int VEC [NVEC][5] = '{
    '{1,  400,  0,  33,   0},
    '{0,  193,  1,  16, 193},
    '{0,  386,  2,  32, 193},
    '{0,  192,  0,  16,   0},
    '{1,   12,  0,   1,   0},
    '{0, 1930, 10, 160, 193}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sampleNow();
    if (!clkEn) begin
      lowCount++;
      if (firstLow == 0) firstLow = curCyc;
      lowSeen[curCyc] = 1'b1;
    end
    if (sampleTick) begin
      tickCount++;
      tickSeen[curCyc] = 1'b1;
    end
  endtask

  task automatic doReset(input logic sel);
    @(negedge clk);
    rstN = 1'b0;
    rateSel = sel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    for (int i = 0; i < 2048; i++) begin lowSeen[i] = 1'b0; tickSeen[i] = 1'b0; end
    lowCount = 0; tickCount = 0; firstLow = 0; curCyc = 1;
    sampleNow();
  endtask

  task automatic runTo(input int last);
    while (curCyc < last) begin
      @(posedge clk);
      #1;
      curCyc++;
      sampleNow();
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    #5_000_000;
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    // R1 reset state in both modes
    doReset(1'b1);
    check(clkEn == 1'b1, "R1 enable after reset", clkEn, 1);
    check(sampleTick == 1'b0, "R1 tick after reset", sampleTick, 0);
    doReset(1'b0);
    check(clkEn == 1'b1, "R1 enable after reset swallow", clkEn, 1);

    // Table walk: R2, R3, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      doReset(VEC[v][0][0]);
      runTo(VEC[v][1]);
      check(lowCount == VEC[v][2], "R2/R3 drop count", lowCount, VEC[v][2]);
      check(tickCount == VEC[v][3], "R5/R6 tick count", tickCount, VEC[v][3]);
      check(firstLow == VEC[v][4], "R2 first drop cycle", firstLow, VEC[v][4]);
    end

    // R5 first tick position in pass mode
    doReset(1'b1);
    runTo(24);
    check(tickSeen[11] == 1'b0, "R5 no tick at 11", tickSeen[11], 0);
    check(tickSeen[12] == 1'b1, "R5 tick at 12", tickSeen[12], 1);
    check(tickSeen[24] == 1'b1, "R5 tick at 24", tickSeen[24], 1);

    // R6 tick gap across a swallowed cycle
    doReset(1'b0);
    runTo(210);
    check(tickSeen[192] == 1'b1, "R6 tick at 192", tickSeen[192], 1);
    check(tickSeen[204] == 1'b0, "R6 no tick at 204", tickSeen[204], 0);
    check(tickSeen[205] == 1'b1, "R6 tick at 205", tickSeen[205], 1);

    // R4 select change mid-frame waits for frame end
    doReset(1'b0);
    runTo(100);
    rateSel = 1'b1;
    runTo(400);
    check(lowSeen[193] == 1'b1, "R4 drop kept at 193", lowSeen[193], 1);
    check(lowSeen[386] == 1'b0, "R4 pass from frame 2", lowSeen[386], 0);
    rateSel = 1'b0;
    runTo(800);
    check(lowSeen[579] == 1'b0, "R4 frame 3 still pass", lowSeen[579], 0);
    check(lowSeen[772] == 1'b1, "R4 swallow from frame 4", lowSeen[772], 1);

    // R4 change in the last cycle of a frame governs the next frame
    doReset(1'b0);
    runTo(193);
    rateSel = 1'b1;
    runTo(400);
    check(lowSeen[386] == 1'b0, "R4 boundary change", lowSeen[386], 0);

    // R8 select level during reset rules frame 1
    doReset(1'b1);
    rateSel = 1'b0;
    runTo(400);
    check(lowSeen[193] == 1'b0, "R8 first frame pass", lowSeen[193], 0);
    check(lowSeen[386] == 1'b1, "R8 second frame swallow", lowSeen[386], 1);

    // R7 master clock stops and restarts
    doReset(1'b0);
    runTo(100);
    @(negedge clk);
    clkRun = 1'b0;
    #2000;
    clkRun = 1'b1;
    runTo(400);
    check(firstLow == 193, "R7 drop position after restart", firstLow, 193);
    check(lowCount == 2, "R7 drop count after restart", lowCount, 2);
    check(tickCount == 33, "R7 tick count after restart", tickCount, 33);

    summary();
  end
endmodule